// File: doc/BRIEF.md
# ALU with Function-Field Control Decoder

This block is the arithmetic core of a simple processor datapath, together with the small decoder that selects its operation. The main decoder supplies a 2-bit operation hint. For loads, stores and immediate instructions the hint forces an addition, which forms an address or adds an immediate. For the equality branch it forces a subtraction, so that the zero flag shows whether the operands are equal. For register-type instructions the hint hands the choice to the 6-bit function field of the instruction, which the decoder turns into a 4-bit control code.

The ALU takes two 32-bit operands. It performs one of six operations: bitwise AND, OR and NOR, addition, subtraction, and a signed set-on-less-than. It returns the result, a carry flag and a zero flag. The decoded control code and an illegal-function indication are also brought out. The block holds no state and has no clock: every output follows its inputs within the same cycle.

Top module: `alu_fn_unit`

## Requirements
- R1: With op_hint_i = 2'b00, ctrl_o is 4'b0010 (add) and illegal_o is 0, whatever funct_i holds.
- R2: With op_hint_i = 2'b01, ctrl_o is 4'b0110 (subtract) and illegal_o is 0, whatever funct_i holds.
- R3: With op_hint_i[1] = 1 (2'b10 or 2'b11), ctrl_o follows funct_i. The mapping is 6'b100000 to add 4'b0010, 6'b100010 to subtract 4'b0110, 6'b100100 to AND 4'b0000, 6'b100101 to OR 4'b0001, 6'b101010 to set-on-less-than 4'b0111, and 6'b100111 to NOR 4'b1100.
- R4: With op_hint_i[1] = 1, any other function code gives ctrl_o = 4'b0000, so the ALU performs AND, and illegal_o = 1. In every other case illegal_o is 0.
- R5: Add returns a_i + b_i modulo 2^32. Subtract returns a_i + ~b_i + 1, which is a_i - b_i modulo 2^32.
- R6: For add, subtract and set-on-less-than, carry_o is the carry out of bit 31 of the adder. For subtract it is therefore 1 when no borrow occurs (a_i >= b_i unsigned). For AND, OR and NOR, carry_o is 0.
- R7: AND, OR and NOR give the bitwise a_i & b_i, a_i | b_i and ~(a_i | b_i).
- R8: Set-on-less-than returns 1 when a_i is less than b_i as signed two's-complement numbers, and 0 otherwise. The comparison is correct even when a_i - b_i overflows. Bits 31..1 of the result are 0.
- R9: zero_o is 1 exactly when result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_hint_i | input | 2 | Operation hint from the main decoder: 00 add, 01 subtract, 1x use function field |
| funct_i | input | 6 | Function field of a register-type instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | ALU result |
| carry_o | output | 1 | Adder carry out (0 for logic operations) |
| zero_o | output | 1 | Result is zero |
| ctrl_o | output | 4 | Decoded ALU control code |
| illegal_o | output | 1 | Function field not recognised in function-field mode |

## Verification
The bench walks the full 6-bit function space under both function-field hints and under both forced hints. A decoder that leaked funct_i into the forced modes, or that failed to flag unknown codes, shows up there as a wrong ctrl_o or illegal_o. Signed set-on-less-than is probed at the overflow points (most negative against 1, most positive against most negative). A design that took only the sign of the difference returns the inverted answer at those points. Subtraction is checked on both sides of the borrow boundary, and on equal operands for the zero flag. A design that used the inverted carry, or an unsigned compare, reports the wrong carry or result there.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;
  localparam int FUNCT_W = 6;
  localparam int CTRL_W  = 4;
  localparam int HINT_W  = 2;

  typedef enum logic [CTRL_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_ctrl_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_fn_pkg::*;
(
  input  logic [HINT_W-1:0]  op_hint_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_ctrl_e          ctrl_o,
  output logic               illegal_o
);

  always_comb begin
    ctrl_o    = ALU_AND;
    illegal_o = 1'b0;
    if (!op_hint_i[1]) begin
      ctrl_o = op_hint_i[0] ? ALU_SUB : ALU_ADD;
    end else begin
      case (funct_i)
        FN_ADD:  ctrl_o = ALU_ADD;
        FN_SUB:  ctrl_o = ALU_SUB;
        FN_AND:  ctrl_o = ALU_AND;
        FN_OR:   ctrl_o = ALU_OR;
        FN_NOR:  ctrl_o = ALU_NOR;
        FN_SLT:  ctrl_o = ALU_SLT;
        default: illegal_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    AST_HINT_ADD: assert (op_hint_i != 2'b00 || (ctrl_o == ALU_ADD && !illegal_o))
      else $error("forced add broken"); // R1
    AST_HINT_SUB: assert (op_hint_i != 2'b01 || (ctrl_o == ALU_SUB && !illegal_o))
      else $error("forced sub broken"); // R2
    AST_ILLEGAL_AND: assert (!illegal_o || (ctrl_o == ALU_AND && op_hint_i[1]))
      else $error("illegal code not mapped to AND"); // R4
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;

  // Subtract as a + ~b + 1; carry out therefore means no borrow.
  always_comb begin
    b_eff            = b_i ^ {W{sub_i}};
    {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    ovf_o            = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign nor_o[i] = ~(a_i[i] | b_i[i]);
  end

endmodule

// File: rtl/alu_fn_unit.sv
module alu_fn_unit
  import alu_fn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [HINT_W-1:0]  op_hint_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o,
  output logic               zero_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               illegal_o
);

  localparam int MSB = DATA_W - 1;

  alu_ctrl_e         ctrl;
  logic              sub_mode;
  logic [DATA_W-1:0] sum;
  logic              add_carry;
  logic              add_ovf;
  logic [DATA_W-1:0] and_v, or_v, nor_v;
  logic              is_arith;

  alu_ctrl_dec u_dec (
    .op_hint_i (op_hint_i),
    .funct_i   (funct_i),
    .ctrl_o    (ctrl),
    .illegal_o (illegal_o)
  );

  assign sub_mode = (ctrl == ALU_SUB) || (ctrl == ALU_SLT);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_mode),
    .sum_o   (sum),
    .carry_o (add_carry),
    .ovf_o   (add_ovf)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  always_comb begin
    case (ctrl)
      ALU_AND:          result_o = and_v;
      ALU_OR:           result_o = or_v;
      ALU_NOR:          result_o = nor_v;
      ALU_ADD, ALU_SUB: result_o = sum;
      // Signed less-than: sign of difference corrected by overflow.
      ALU_SLT:          result_o = {{MSB{1'b0}}, sum[MSB] ^ add_ovf};
      default:          result_o = '0;
    endcase
  end

  assign is_arith = (ctrl == ALU_ADD) || sub_mode;
  assign carry_o  = is_arith & add_carry;
  assign zero_o   = ~|result_o;
  assign ctrl_o   = ctrl;

  always_comb begin
    AST_ADD_SUM: assert (ctrl != ALU_ADD || result_o == a_i + b_i)
      else $error("add result wrong"); // R5
    AST_SUB_DIFF: assert (ctrl != ALU_SUB || result_o == a_i - b_i)
      else $error("sub result wrong"); // R5
    AST_SUB_BORROW: assert (ctrl != ALU_SUB || carry_o == (a_i >= b_i))
      else $error("sub carry wrong"); // R6
    AST_LOGIC_NO_CARRY: assert (is_arith || !carry_o)
      else $error("carry on logic op"); // R6
    AST_NOR_DISJOINT: assert (ctrl != ALU_NOR || (((result_o & (a_i | b_i)) == '0) && ((result_o | a_i | b_i) == '1)))
      else $error("nor result wrong"); // R7
    AST_SLT_UPPER: assert (ctrl != ALU_SLT || result_o[MSB:1] == '0)
      else $error("slt upper bits set"); // R8
    AST_SLT_SIGNED: assert (ctrl != ALU_SLT || result_o[0] == ($signed(a_i) < $signed(b_i)))
      else $error("slt compare wrong"); // R8
    AST_ZERO_EQUAL: assert (ctrl != ALU_SUB || a_i != b_i || zero_o)
      else $error("zero missed on equal"); // R9
  end

endmodule

// File: tb/alu_fn_unit_test.sv
`timescale 1ns/1ps
module alu_fn_unit_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  op_hint;
  logic [5:0]  funct;
  logic [31:0] a, b, result;
  logic        carry, zero, illegal;
  logic [3:0]  ctrl;

  int n_chk = 0;
  int n_bad = 0;

  alu_fn_unit uut (
    .op_hint_i (op_hint),
    .funct_i   (funct),
    .a_i       (a),
    .b_i       (b),
    .result_o  (result),
    .carry_o   (carry),
    .zero_o    (zero),
    .ctrl_o    (ctrl),
    .illegal_o (illegal)
  );

  typedef struct packed {
    logic [1:0]  hint;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        c;
    logic        z;
    logic        ill;
    logic [3:0]  ctl;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 6'h20, 32'd5,         32'd7,         32'd12,        1'b0, 1'b0, 1'b0, 4'h2},
    '{2'b10, 6'h20, 32'hFFFFFFFF,  32'd1,         32'd0,         1'b1, 1'b1, 1'b0, 4'h2},
    '{2'b10, 6'h22, 32'd10,        32'd3,         32'd7,         1'b1, 1'b0, 1'b0, 4'h6},
    '{2'b10, 6'h22, 32'd3,         32'd10,        32'hFFFFFFF9,  1'b0, 1'b0, 1'b0, 4'h6},
    '{2'b10, 6'h22, 32'h1234,      32'h1234,      32'd0,         1'b1, 1'b1, 1'b0, 4'h6},
    '{2'b10, 6'h24, 32'hF0F0F0F0,  32'hFF00FF00,  32'hF000F000,  1'b0, 1'b0, 1'b0, 4'h0},
    '{2'b10, 6'h25, 32'hF0F0F0F0,  32'h0F0F0000,  32'hFFFFF0F0,  1'b0, 1'b0, 1'b0, 4'h1},
    '{2'b10, 6'h2A, 32'hFFFFFFFF,  32'd1,         32'd1,         1'b1, 1'b0, 1'b0, 4'h7},
    '{2'b10, 6'h2A, 32'd1,         32'hFFFFFFFF,  32'd0,         1'b0, 1'b1, 1'b0, 4'h7},
    '{2'b10, 6'h2A, 32'h80000000,  32'd1,         32'd1,         1'b1, 1'b0, 1'b0, 4'h7},
    '{2'b10, 6'h2A, 32'h7FFFFFFF,  32'h80000000,  32'd0,         1'b0, 1'b1, 1'b0, 4'h7},
    '{2'b00, 6'h22, 32'd100,       32'hFFFFFFFC,  32'd96,        1'b1, 1'b0, 1'b0, 4'h2},
    '{2'b01, 6'h20, 32'd8,         32'd8,         32'd0,         1'b1, 1'b1, 1'b0, 4'h6},
    '{2'b10, 6'h3F, 32'hFFFF0000,  32'h0FF00FF0,  32'h0FF00000,  1'b0, 1'b0, 1'b1, 4'h0},
    '{2'b00, 6'h3F, 32'd1,         32'd2,         32'd3,         1'b0, 1'b0, 1'b0, 4'h2},
    '{2'b11, 6'h25, 32'd0,         32'd0,         32'd0,         1'b0, 1'b1, 1'b0, 4'h1},
    '{2'b10, 6'h27, 32'hF0F0F0F0,  32'h0F0F0000,  32'h00000F0F,  1'b0, 1'b0, 1'b0, 4'hC},
    '{2'b11, 6'h27, 32'hFFFFFFFF,  32'd0,         32'd0,         1'b0, 1'b1, 1'b0, 4'hC}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] h, input logic [5:0] f,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op_hint = h; funct = f; a = x; b = y;
    #1;
  endtask

  // Decoder expectation from R1..R4
  function automatic logic [4:0] ref_dec(input logic [1:0] h, input logic [5:0] f);
    if (h == 2'b00) return {1'b0, 4'h2};
    if (h == 2'b01) return {1'b0, 4'h6};
    case (f)
      6'b100000: return {1'b0, 4'h2};
      6'b100010: return {1'b0, 4'h6};
      6'b100100: return {1'b0, 4'h0};
      6'b100101: return {1'b0, 4'h1};
      6'b101010: return {1'b0, 4'h7};
      6'b100111: return {1'b0, 4'hC};
      default:   return {1'b1, 4'h0};
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    op_hint = 2'b00; funct = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // Idle state after reset: zero operands added
    apply(2'b00, 6'h00, 32'd0, 32'd0);
    chk("R9 reset zero flag", {31'd0, zero}, 32'd1);
    chk("R1 reset ctrl", {28'd0, ctrl}, 32'h2);
    chk("R6 reset carry", {31'd0, carry}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].hint, VECS[i].fn, VECS[i].a, VECS[i].b);
      chk($sformatf("R5 R7 R8 result vec %0d", i), result, VECS[i].res);
      chk($sformatf("R6 carry vec %0d", i), {31'd0, carry}, {31'd0, VECS[i].c});
      chk($sformatf("R9 zero vec %0d", i), {31'd0, zero}, {31'd0, VECS[i].z});
      chk($sformatf("R1 R2 R3 ctrl vec %0d", i), {28'd0, ctrl}, {28'd0, VECS[i].ctl});
      chk($sformatf("R4 illegal vec %0d", i), {31'd0, illegal}, {31'd0, VECS[i].ill});
    end

    // Full function-field sweep under every hint
    for (int h = 0; h < 4; h++) begin
      for (int f = 0; f < 64; f++) begin
        logic [4:0] e;
        e = ref_dec(2'(h), 6'(f));
        apply(2'(h), 6'(f), 32'h0000_00F0, 32'h0000_0F00);
        chk($sformatf("R1 R2 R3 sweep ctrl h%0d f%0h", h, f), {28'd0, ctrl}, {28'd0, e[3:0]});
        chk($sformatf("R4 sweep illegal h%0d f%0h", h, f), {31'd0, illegal}, {31'd0, e[4]});
      end
    end

    // Pseudo-random arithmetic against reference
    for (int k = 0; k < 200; k++) begin
      logic [31:0] x, y;
      logic [32:0] w;
      x = $urandom; y = $urandom;
      if (k % 8 == 0) y = x;
      apply(2'b00, 6'h3F, x, y);
      w = {1'b0, x} + {1'b0, y};
      chk("R5 rand add", result, w[31:0]);
      chk("R6 rand add carry", {31'd0, carry}, {31'd0, w[32]});
      apply(2'b01, 6'h3F, x, y);
      chk("R5 rand sub", result, x - y);
      chk("R6 rand sub no-borrow", {31'd0, carry}, {31'd0, (x >= y)});
      chk("R9 rand sub zero", {31'd0, zero}, {31'd0, (x == y)});
      apply(2'b10, 6'h2A, x, y);
      chk("R8 rand slt", result, {31'd0, ($signed(x) < $signed(y))});
      apply(2'b10, 6'h27, x, y);
      chk("R7 rand nor", result, ~(x | y));
      chk("R6 rand nor carry", {31'd0, carry}, 32'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule